// File: doc/BRIEF.md
# Picture-in-Picture Overlay Window Generator

This block decides, for every display pixel, what the video output stage should show. It counts pixels and lines from a pixel-rate enable and the display sync inputs. From those counts it places a background rectangle and two picture-in-picture windows, called main and sub. Each window has its own offset and its own size. The block reports a region code for the pixel, the window-local column and row that the memory fetch logic uses to address the stored picture, and a fast-blanking flag that switches the output multiplexer away from live video.

The background rectangle has a fixed width. Its height follows the selected field standard. A fine-position offset moves it relative to sync. Both windows are measured from the background corner and are cut off at its edges. Each window's size is the acquired picture size divided by a reduction factor of 1 to 4, set separately for width and height. A byte-wide write port loads all settings into a pending copy. That copy becomes active at the next frame start, so a picture is never drawn with a mix of old and new settings.

Top module: `pip_overlay_gen`

## Requirements
- R1: A pixel slot is a clock cycle with `pix_en` high. In the slot where `hsync` rises, the column count becomes 0 and the line count advances. In the slot where `vsync` rises, the line count becomes 0. Every other slot advances the column count by one.
- R2: The background spans columns `BG_HBASE+hofs` to `BG_HBASE+hofs+BG_W-1` and lines `BG_VBASE+vofs` onward. It is `BG_H60` lines tall when the standard bit is 0 and `BG_H50` lines tall when it is 1.
- R3: The background enable bit affects only the background region. Windows show inside the background area whether or not the background is enabled.
- R4: A window is `ACQ_W/(ch+1)` columns wide and `ACQ_Hx/(cv+1)` lines tall, rounded down. `ch` and `cv` are its 2-bit reduction codes, and `ACQ_Hx` follows the standard bit.
- R5: A window's first column is the background's first column plus its horizontal position. Its first line is the background's first line plus its vertical position.
- R6: `region` encodes 0 none, 1 background, 2 main, 3 sub. Main wins over sub, and sub wins over background. A window only counts when its enable bit is set.
- R7: No window pixel is reported outside the background rectangle.
- R8: `fast_blank` is high exactly when `region` is not 0.
- R9: Inside a window, `pip_x` and `pip_y` give the offset from that window's first column and first line. Outside any window both are 0.
- R10: Writes go to a pending copy and reach the outputs only at the next `vsync` rising slot. The write addresses are:
  - 0: control. Bit 0 background enable, bit 1 main enable, bit 2 sub enable, bit 3 standard.
  - 1: style. Bits 2:0 colour, bits 4:3 brightness.
  - 2 and 3: background horizontal and vertical offset.
  - 4 and 5: main horizontal and vertical position.
  - 6 and 7: sub horizontal and vertical position.
  - 8: reduction codes. Bits 1:0 sub horizontal, 3:2 sub vertical, 5:4 main horizontal, 7:6 main vertical.
  - Addresses 9 and above are ignored.
- R11: `bg_colour` (0 to 7) and `bg_bright` (0=30%, 1=50%, 2=70%, 3=100%) show the active style settings.
- R12: After reset all settings are 0, so `region` is 0, `fast_blank` is 0 and the style outputs are 0.
- R13: In cycles with `pix_en` low, no output changes unless a frame start is also loading new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Display pixel-rate enable |
| hsync | input | 1 | Display horizontal sync, rising edge starts a line |
| vsync | input | 1 | Display vertical sync, rising edge starts a frame |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | ADDR_W | Settings write address |
| cfg_wdata | input | 8 | Settings write data |
| region | output | 2 | Region code of the current pixel |
| fast_blank | output | 1 | Overlay active |
| pip_x | output | CW | Window-local column |
| pip_y | output | CW | Window-local line |
| bg_colour | output | 3 | Active background colour |
| bg_bright | output | 2 | Active background brightness code |

## Verification
The hardest case to reach is a pixel where several rules meet at once. Examples are an overlap of both windows lying on a clipped background edge, or a settings change written mid-frame that must stay invisible until the next frame. The stimulus starts with directed frames that stack both windows at one position, push a reduced window past the background's bottom-right corner, and place the background against the end of the line. Random frames follow, each of which writes the next frame's settings partway through its own lines, so every pixel after the write still has to match the old settings. Idle cycles are inserted at random between pixel slots, so the counters are also seen holding still.

// File: rtl/pipw_pkg.sv
package pipw_pkg;

   typedef enum logic [1:0] {
      RG_NONE = 2'd0,
      RG_BG   = 2'd1,
      RG_MAIN = 2'd2,
      RG_SUB  = 2'd3
   } region_e;

   localparam int POSW = 8;

   typedef struct packed {
      logic            std50;
      logic            sub_on;
      logic            main_on;
      logic            bg_on;
      logic [2:0]      colour;
      logic [1:0]      bright;
      logic [POSW-1:0] bg_hofs;
      logic [POSW-1:0] bg_vofs;
      logic [POSW-1:0] m_h;
      logic [POSW-1:0] m_v;
      logic [POSW-1:0] s_h;
      logic [POSW-1:0] s_v;
      logic [1:0]      m_rh;
      logic [1:0]      m_rv;
      logic [1:0]      s_rh;
      logic [1:0]      s_rv;
   } cfg_t;

endpackage

// File: rtl/pipw_timing.sv
module pipw_timing #(
   parameter int HW = 11,
   parameter int VW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_en,
   input  logic          hsync,
   input  logic          vsync,
   output logic [HW-1:0] hcnt,
   output logic [VW-1:0] vcnt,
   output logic          frame_start
);

   logic hs_q, vs_q, line_start;

   assign line_start  = pix_en && hsync && !hs_q;
   assign frame_start = pix_en && vsync && !vs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q <= 1'b0;
         vs_q <= 1'b0;
         hcnt <= '0;
         vcnt <= '0;
      end else if (pix_en) begin
         hs_q <= hsync;
         vs_q <= vsync;
         if (line_start)
            hcnt <= '0;
         else if (hcnt != '1)
            hcnt <= hcnt + 1'b1;
         if (frame_start)
            vcnt <= '0;
         else if (line_start && vcnt != '1)
            vcnt <= vcnt + 1'b1;
      end
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> ($stable(hcnt) && $stable(vcnt))); // R13

endmodule

// File: rtl/pipw_cfg.sv
module pipw_cfg
   import pipw_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   input  logic          load,
   output cfg_t          act
);

   cfg_t pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
      end else if (we) begin
         case (int'(addr))
            0: begin
               pend.bg_on   <= wdata[0];
               pend.main_on <= wdata[1];
               pend.sub_on  <= wdata[2];
               pend.std50   <= wdata[3];
            end
            1: begin
               pend.colour <= wdata[2:0];
               pend.bright <= wdata[4:3];
            end
            2: pend.bg_hofs <= wdata;
            3: pend.bg_vofs <= wdata;
            4: pend.m_h     <= wdata;
            5: pend.m_v     <= wdata;
            6: pend.s_h     <= wdata;
            7: pend.s_v     <= wdata;
            8: begin
               pend.s_rh <= wdata[1:0];
               pend.s_rv <= wdata[3:2];
               pend.m_rh <= wdata[5:4];
               pend.m_rv <= wdata[7:6];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act <= '0;
      else if (load)
         act <= pend;
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(act)); // R10

endmodule

// File: rtl/pipw_window.sv
module pipw_window #(
   parameter int CW      = 12,
   parameter int ACQ_W   = 672,
   parameter int ACQ_H60 = 228,
   parameter int ACQ_H50 = 276
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          in_bg,
   input  logic          std50,
   input  logic [CW-1:0] bx,
   input  logic [CW-1:0] by,
   input  logic [7:0]    pos_h,
   input  logic [7:0]    pos_v,
   input  logic [1:0]    red_h,
   input  logic [1:0]    red_v,
   output logic          hit,
   output logic [CW-1:0] lx,
   output logic [CW-1:0] ly
);

   logic [CW-1:0] w, h, ph, pv, dx, dy;

   always_comb begin
      case (red_h)
         2'd0:    w = CW'(ACQ_W);
         2'd1:    w = CW'(ACQ_W / 2);
         2'd2:    w = CW'(ACQ_W / 3);
         default: w = CW'(ACQ_W / 4);
      endcase
      case (red_v)
         2'd0:    h = std50 ? CW'(ACQ_H50)     : CW'(ACQ_H60);
         2'd1:    h = std50 ? CW'(ACQ_H50 / 2) : CW'(ACQ_H60 / 2);
         2'd2:    h = std50 ? CW'(ACQ_H50 / 3) : CW'(ACQ_H60 / 3);
         default: h = std50 ? CW'(ACQ_H50 / 4) : CW'(ACQ_H60 / 4);
      endcase
   end

   assign ph  = CW'(pos_h);
   assign pv  = CW'(pos_v);
   assign dx  = bx - ph;
   assign dy  = by - pv;
   assign hit = en && in_bg && (bx >= ph) && (dx < w) && (by >= pv) && (dy < h);
   assign lx  = hit ? dx : '0;
   assign ly  = hit ? dy : '0;

   AST_LOCAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ((lx < w) && (ly < h))); // R4

endmodule

// File: rtl/pip_overlay_gen.sv
module pip_overlay_gen
   import pipw_pkg::*;
#(
   parameter int LINE_PIX  = 864,
   parameter int MAX_LINES = 320,
   parameter int BG_W      = 696,
   parameter int BG_H60    = 238,
   parameter int BG_H50    = 286,
   parameter int ACQ_W     = 672,
   parameter int ACQ_H60   = 228,
   parameter int ACQ_H50   = 276,
   parameter int BG_HBASE  = 96,
   parameter int BG_VBASE  = 20,
   parameter int ADDR_W    = 4,
   localparam int HW    = $clog2(LINE_PIX) + 1,
   localparam int VW    = $clog2(MAX_LINES) + 1,
   localparam int XSPAN = LINE_PIX + BG_HBASE + (1 << POSW) + BG_W,
   localparam int YSPAN = MAX_LINES + BG_VBASE + (1 << POSW) + BG_H50,
   localparam int CW    = $clog2((XSPAN > YSPAN) ? XSPAN : YSPAN) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_en,
   input  logic              hsync,
   input  logic              vsync,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [1:0]        region,
   output logic              fast_blank,
   output logic [CW-1:0]     pip_x,
   output logic [CW-1:0]     pip_y,
   output logic [2:0]        bg_colour,
   output logic [1:0]        bg_bright
);

   localparam int NCH = 2;

   if (ACQ_W > BG_W) begin : g_bad_w
      $error("acquisition width exceeds background width");
   end
   if (ACQ_H60 > BG_H60 || ACQ_H50 > BG_H50) begin : g_bad_h
      $error("acquisition height exceeds background height");
   end
   if (ADDR_W < 4) begin : g_bad_a
      $error("address width too small for settings map");
   end
   if (LINE_PIX < 2 || MAX_LINES < 2) begin : g_bad_t
      $error("timing counts too small");
   end

   logic [HW-1:0] hcnt;
   logic [VW-1:0] vcnt;
   logic          frame_start;
   cfg_t          act;

   pipw_timing #(.HW(HW), .VW(VW)) u_tim (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hsync(hsync),
      .vsync(vsync), .hcnt(hcnt), .vcnt(vcnt), .frame_start(frame_start)
   );

   pipw_cfg #(.AW(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .load(frame_start), .act(act)
   );

   logic [CW-1:0] hx, vy, bg_x0, bg_y0, bx, by, bg_h;
   logic          in_bg;

   assign hx    = CW'(hcnt);
   assign vy    = CW'(vcnt);
   assign bg_x0 = CW'(BG_HBASE) + CW'(act.bg_hofs);
   assign bg_y0 = CW'(BG_VBASE) + CW'(act.bg_vofs);
   assign bx    = hx - bg_x0;
   assign by    = vy - bg_y0;
   assign bg_h  = act.std50 ? CW'(BG_H50) : CW'(BG_H60);
   assign in_bg = (hx >= bg_x0) && (bx < CW'(BG_W)) && (vy >= bg_y0) && (by < bg_h);

   logic [NCH-1:0] hit;
   logic [CW-1:0]  lx [NCH];
   logic [CW-1:0]  ly [NCH];

   for (genvar ch = 0; ch < NCH; ch++) begin : g_win
      pipw_window #(
         .CW(CW), .ACQ_W(ACQ_W), .ACQ_H60(ACQ_H60), .ACQ_H50(ACQ_H50)
      ) u_win (
         .clk   (clk),
         .rst_n (rst_n),
         .en    ((ch == 0) ? act.main_on : act.sub_on),
         .in_bg (in_bg),
         .std50 (act.std50),
         .bx    (bx),
         .by    (by),
         .pos_h ((ch == 0) ? act.m_h  : act.s_h),
         .pos_v ((ch == 0) ? act.m_v  : act.s_v),
         .red_h ((ch == 0) ? act.m_rh : act.s_rh),
         .red_v ((ch == 0) ? act.m_rv : act.s_rv),
         .hit   (hit[ch]),
         .lx    (lx[ch]),
         .ly    (ly[ch])
      );
   end

   region_e rg;

   always_comb begin
      rg    = RG_NONE;
      pip_x = '0;
      pip_y = '0;
      if (hit[0]) begin
         rg    = RG_MAIN;
         pip_x = lx[0];
         pip_y = ly[0];
      end else if (hit[1]) begin
         rg    = RG_SUB;
         pip_x = lx[1];
         pip_y = ly[1];
      end else if (act.bg_on && in_bg) begin
         rg = RG_BG;
      end
   end

   assign region     = rg;
   assign fast_blank = (rg != RG_NONE);
   assign bg_colour  = act.colour;
   assign bg_bright  = act.bright;

   AST_REGION_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (region != RG_NONE) |-> in_bg); // R7

   AST_MAIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_MAIN) |-> act.main_on); // R6

   AST_SUB_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      hit[0] |-> (region == RG_MAIN)); // R6

endmodule

// File: tb/sim_pip_overlay_gen.sv
module sim_pip_overlay_gen;

   localparam int LINE = 64;
   localparam int ML   = 32;
   localparam int BW   = 40;
   localparam int BH60 = 14;
   localparam int BH50 = 18;
   localparam int AW_  = 24;
   localparam int AH60 = 12;
   localparam int AH50 = 16;
   localparam int HB   = 4;
   localparam int VB   = 2;
   localparam int NL   = 26;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n, pix_en, hsync, vsync, cfg_we;
   logic [3:0] cfg_addr;
   logic [7:0] cfg_wdata;
   logic [1:0] region;
   logic       fast_blank;
   logic [2:0] bg_colour;
   logic [1:0] bg_bright;
   logic [9:0] pip_x, pip_y;

   pip_overlay_gen #(
      .LINE_PIX(LINE), .MAX_LINES(ML), .BG_W(BW), .BG_H60(BH60), .BG_H50(BH50),
      .ACQ_W(AW_), .ACQ_H60(AH60), .ACQ_H50(AH50), .BG_HBASE(HB), .BG_VBASE(VB),
      .ADDR_W(4)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hsync(hsync), .vsync(vsync),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .region(region), .fast_blank(fast_blank), .pip_x(pip_x), .pip_y(pip_y),
      .bg_colour(bg_colour), .bg_bright(bg_bright)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;
   logic [7:0] pend_r [9];
   logic [7:0] act_r  [9];
   int cur_x = 0;
   int cur_y = 0;

   task automatic chk(input bit ok, input string req, input int actv, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s at x=%0d y=%0d: actual=%0d expected=%0d", req, cur_x, cur_y, actv, expv);
      end
   endtask

   task automatic model(input int x, input int y, output int rg, output int px, output int py);
      int bx0, by0, bh, bx, by, std, hitm, hits, ib;
      int w [2];
      int h [2];
      int ph [2];
      int pv [2];
      int on [2];
      int lxv [2];
      int lyv [2];
      int hitv [2];
      std = act_r[0][3];
      bx0 = HB + act_r[2];
      by0 = VB + act_r[3];
      bh  = std ? BH50 : BH60;
      ib  = (x >= bx0 && x < bx0 + BW && y >= by0 && y < by0 + bh) ? 1 : 0;
      bx  = x - bx0;
      by  = y - by0;
      on[0] = act_r[0][1]; on[1] = act_r[0][2];
      ph[0] = act_r[4]; pv[0] = act_r[5];
      ph[1] = act_r[6]; pv[1] = act_r[7];
      w[0] = AW_ / (int'(act_r[8][5:4]) + 1);
      h[0] = (std ? AH50 : AH60) / (int'(act_r[8][7:6]) + 1);
      w[1] = AW_ / (int'(act_r[8][1:0]) + 1);
      h[1] = (std ? AH50 : AH60) / (int'(act_r[8][3:2]) + 1);
      for (int c = 0; c < 2; c++) begin
         hitv[c] = (on[c] != 0 && ib != 0 && bx >= ph[c] && bx < ph[c] + w[c] &&
                    by >= pv[c] && by < pv[c] + h[c]) ? 1 : 0;
         lxv[c] = bx - ph[c];
         lyv[c] = by - pv[c];
      end
      hitm = hitv[0]; hits = hitv[1];
      rg = 0; px = 0; py = 0;
      if (hitm != 0) begin rg = 2; px = lxv[0]; py = lyv[0]; end
      else if (hits != 0) begin rg = 3; px = lxv[1]; py = lyv[1]; end
      else if (act_r[0][0] && ib != 0) rg = 1;
   endtask

   task automatic check_state(input string extra);
      int rg, px, py;
      model(cur_x, cur_y, rg, px, py);
      chk(int'(region) == rg, {"R2/R3/R4/R5/R6/R7 region", extra}, int'(region), rg);
      chk(int'(fast_blank) == (rg != 0 ? 1 : 0), {"R8 fast_blank", extra}, int'(fast_blank), (rg != 0 ? 1 : 0));
      chk(int'(pip_x) == px && int'(pip_y) == py, {"R9 pip_x*64+pip_y", extra},
          int'(pip_x) * 64 + int'(pip_y), px * 64 + py);
      chk(int'(bg_colour) == int'(act_r[1][2:0]) && int'(bg_bright) == int'(act_r[1][4:3]),
          {"R11 style", extra}, int'({bg_bright, bg_colour}), int'({act_r[1][4:3], act_r[1][2:0]}));
   endtask

   task automatic pixel(input bit hs, input bit vs, input int x, input int y);
      pix_en = 1'b1; hsync = hs; vsync = vs;
      @(posedge clk);
      if (vs) for (int i = 0; i < 9; i++) act_r[i] = pend_r[i];
      cur_x = x; cur_y = y;
      @(negedge clk);
      pix_en = 1'b0; hsync = 1'b0; vsync = 1'b0;
      check_state(" R1");
   endtask

   task automatic idle();
      @(posedge clk);
      @(negedge clk);
      check_state(" R13");
   endtask

   task automatic wr(input int a, input int d);
      cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
      @(posedge clk);
      if (a < 9) pend_r[a] = 8'(d);
      @(negedge clk);
      cfg_we = 1'b0;
      check_state(" R10");
   endtask

   task automatic rand_writes();
      wr(0, $urandom % 16);
      wr(1, $urandom % 32);
      wr(2, $urandom % 24);
      wr(3, $urandom % 6);
      wr(4, $urandom % 48);
      wr(5, $urandom % 20);
      wr(6, $urandom % 48);
      wr(7, $urandom % 20);
      wr(8, $urandom % 256);
      wr(9 + ($urandom % 7), $urandom % 256);  // R10 ignored address
   endtask

   task automatic run_frame(input bit do_wr);
      int wl;
      wl = 3 + ($urandom % 15);
      for (int y = 0; y < NL; y++) begin
         for (int x = 0; x < LINE; x++) begin
            pixel(x == 0, (x == 0 && y == 0), x, y);
            if ($urandom % 4 == 0) idle();
            if (do_wr && y == wl && x == 20) rand_writes();
         end
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=1 expected=0");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < 9; i++) begin pend_r[i] = 8'h00; act_r[i] = 8'h00; end
      rst_n = 1'b0; pix_en = 1'b0; hsync = 1'b0; vsync = 1'b0;
      cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_state(" R12 reset");

      // Directed: full-size windows stacked, 60 Hz, colour 5 brightness 2
      wr(0, 4'b0111); wr(1, (2 << 3) | 5);
      wr(2, 0); wr(3, 0);
      wr(4, 2); wr(5, 1); wr(6, 2); wr(7, 1); wr(8, 0);
      check_state(" R10 before frame");
      run_frame(1'b0);

      // Directed: 50 Hz, background off, main clipped at bottom-right corner
      wr(0, 4'b1110); wr(1, 7);
      wr(4, 36); wr(5, 15); wr(6, 0); wr(7, 0);
      wr(8, (2 << 6) | (2 << 4) | (3 << 2) | 3);
      run_frame(1'b0);

      // Directed: background only, pushed against end of line
      wr(0, 4'b0001); wr(1, (3 << 3) | 1); wr(2, 22); wr(3, 5);
      run_frame(1'b0);

      // Directed: sub only, factor 3 both ways, overlapping disabled main
      wr(0, 4'b0101); wr(2, 3); wr(3, 1);
      wr(4, 0); wr(5, 0); wr(6, 5); wr(7, 2);
      wr(8, (2 << 2) | 2);
      run_frame(1'b1);

      for (int f = 0; f < 20; f++) run_frame(1'b1);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule